// File: doc/BRIEF.md
# Stereo Serial Audio Output Formatter

This block turns a stream of parallel stereo sample pairs into a three-clock serial audio output. A single master clock runs at 320 times the output sample rate. From it the block divides a bit clock (five master clocks per bit), a left/right clock at the sample rate, and a word clock at twice the sample rate. Sample pairs arrive over a valid/ready handshake and are shifted out MSB first on one serial data line.

A rate select picks how sample data fills each 64-bit frame. In normal-rate mode one pair is sent per frame, with each channel right-justified in its own 32-bit LR half. In double-rate mode two pairs are sent per frame. Each word-clock period carries one whole pair, left while the word clock is high and right while it is low, right-justified in 16-bit halves. A pass-through flag forces the word clock low and leaves every other output as it is. When no new pair has arrived by a load point, the previous pair is sent again, so the serial stream never stalls.

Top module: `aud_out_fmt`

## Requirements
- R1: The bit clock has a period of DIV master clocks. It is low for the first DIV/2 master clocks of each bit period and high for the rest. A frame holds 64 bit periods.
- R2: The LR clock is low for bit periods 0 to 31 of each frame (left half) and high for bit periods 32 to 63 (right half).
- R3: When pass-through is off, the word clock is high for the first 16 bit periods of each LR half and low for the last 16. Each LR edge therefore falls where the word clock is high.
- R4: With pass_i = 1 latched at a frame start, the word clock stays low for that entire frame. Bit clock, LR clock and data are unaffected.
- R5: With rate_i = 0 (normal rate), each LR half carries one channel. Left goes in the LR-low half. The half starts with SLOT_BITS-SAMPLE_W zero bits, followed by the sample MSB first.
- R6: With rate_i = 1 (double rate), each word-clock period carries one pair. Left is sent while the word clock is high and right while it is low. Each 16-bit half starts with SLOT_BITS/2-SAMPLE_W zero bits, followed by the sample MSB first.
- R7: Pairs are loaded for output at each frame start. In double-rate mode they are also loaded at bit 32. Accepted pairs appear on the serial line in acceptance order, and none is lost.
- R8: If no accepted pair is waiting at a load point, the pair already being sent is sent again.
- R9: ready_o is high while the single holding register is empty. A pair is accepted on a clock edge with valid_i and ready_o both high. ready_o then stays low until that pair moves to the output at a load point.
- R10: rate_i and pass_i are sampled only at frame starts. A change in mid-frame leaves the frame in progress untouched. The first frame after reset uses normal rate with pass-through off.
- R11: rst_ni is asynchronous and active low, and its release is synchronised over two master clocks. While rst_ni is low, bclk_o, lrclk_o and sdata_o are low and ready_o is high.
- R12: sdata_o, lrclk_o and wclk_o change only on the master clock edge where the bit clock falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock, 320 times the output sample rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| left_i | input | SAMPLE_W | Left sample of the offered pair |
| right_i | input | SAMPLE_W | Right sample of the offered pair |
| valid_i | input | 1 | Offered pair is valid |
| ready_o | output | 1 | Holding register can take a pair |
| rate_i | input | 1 | 0: normal-rate data, 1: double-rate data |
| pass_i | input | 1 | 1: pass-through, word clock held low |
| bclk_o | output | 1 | Bit clock, 64 times the sample rate |
| lrclk_o | output | 1 | Left/right clock at the sample rate |
| wclk_o | output | 1 | Word clock at twice the sample rate |
| sdata_o | output | 1 | Serial sample data, MSB first |

## Verification
The bench builds the block with SAMPLE_W = 12, SLOT_BITS = 32 and DIV = 5. The 12-bit sample leaves zero padding in both modes, so right-justification and bit order can be seen in double-rate halves as well as normal-rate slots. A 32-bit slot keeps the word-clock and LR timing at their usual 16/32-bit spacing. DIV = 5 gives an odd bit period with an uneven bit-clock duty. The scoreboard follows pairs across rate switches made in mid-frame and across pass-through toggles. This exercises the frame-start latching and the repeat-on-starvation path between the streaming phases.

// File: rtl/aof_pkg.sv
package aof_pkg;

  // Data-rate selection for the serial stream
  typedef enum logic {
    RATE_FS  = 1'b0,
    RATE_2FS = 1'b1
  } rate_e;

endpackage

// File: rtl/aof_timing.sv
module aof_timing
  import aof_pkg::*;
#(
  parameter int DIV       = 5,
  parameter int SLOT_BITS = 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           rate_i,
  input  logic                           pass_i,
  output logic [$clog2(2*SLOT_BITS)-1:0] bit_o,
  output logic                           bit_edge_o,
  output logic                           load_o,
  output rate_e                          rate_o,
  output logic                           bclk_o,
  output logic                           lrclk_o,
  output logic                           wclk_o
);

  localparam int FRAME_BITS = 2 * SLOT_BITS;
  localparam int BW         = $clog2(FRAME_BITS);
  localparam int DW         = $clog2(DIV);
  localparam int HL         = $clog2(SLOT_BITS) - 1;
  localparam int RISE       = DIV / 2;

  logic [DW-1:0] div_q, div_d;
  logic [BW-1:0] bit_q, bit_d;
  rate_e         rate_q, rate_d;
  logic          pass_q, pass_d;
  logic          div_last, frame_wrap, mid_wrap;

  // next-state
  always_comb begin
    div_last   = (div_q == DW'(DIV - 1));
    frame_wrap = div_last && (bit_q == BW'(FRAME_BITS - 1));
    mid_wrap   = div_last && (bit_q == BW'(SLOT_BITS - 1));
    div_d      = div_last ? '0 : div_q + 1'b1;
    bit_d      = bit_q + 1'b1;
    rate_d     = rate_e'(rate_i);
    pass_d     = pass_i;
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      bit_q  <= '0;
      rate_q <= RATE_FS;
      pass_q <= 1'b0;
    end else begin
      div_q <= div_d;
      if (div_last) begin
        bit_q <= bit_d;
      end
      if (frame_wrap) begin
        rate_q <= rate_d;
        pass_q <= pass_d;
      end
    end
  end

  assign load_o     = frame_wrap | (mid_wrap & (rate_q == RATE_2FS));
  assign bit_o      = bit_q;
  assign bit_edge_o = (div_q == '0);
  assign rate_o     = rate_q;
  assign bclk_o     = (div_q >= DW'(RISE));
  assign lrclk_o    = bit_q[BW-1];
  assign wclk_o     = ~pass_q & ~bit_q[HL];

  // mode flags only move at a frame boundary
  assert_rate_at_frame_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(rate_q) || !$stable(pass_q)) |-> (bit_q == '0 && div_q == '0));

  // an LR edge lands inside the high half of a word-clock period
  assert_lr_in_word_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lrclk_o) |-> (pass_q || wclk_o));

endmodule

// File: rtl/aof_pair_buf.sv
module aof_pair_buf #(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  input  logic                valid_i,
  output logic                ready_o,
  input  logic                load_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o
);

  logic                full_q, full_d;
  logic [SAMPLE_W-1:0] hold_l_q, hold_r_q;
  logic [SAMPLE_W-1:0] cur_l_q, cur_r_q;
  logic                accept, take;

  // next-state
  always_comb begin
    accept = valid_i & ~full_q;
    take   = load_i & full_q;
    full_d = full_q ? ~load_i : accept;
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q   <= 1'b0;
      hold_l_q <= '0;
      hold_r_q <= '0;
      cur_l_q  <= '0;
      cur_r_q  <= '0;
    end else begin
      full_q <= full_d;
      if (accept) begin
        hold_l_q <= left_i;
        hold_r_q <= right_i;
      end
      if (take) begin
        cur_l_q <= hold_l_q;
        cur_r_q <= hold_r_q;
      end
    end
  end

  assign ready_o = ~full_q;
  assign left_o  = cur_l_q;
  assign right_o = cur_r_q;

  // a held pair survives until a load point moves it out
  assert_hold_kept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && !load_i) |=> (full_q && $stable(hold_l_q) && $stable(hold_r_q)));

  // the output pair moves only right after a load point
  assert_cur_on_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(cur_l_q) || !$stable(cur_r_q)) |-> $past(load_i));

  // starved load point keeps the current pair
  assert_repeat_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !full_q) |=> ($stable(cur_l_q) && $stable(cur_r_q)));

endmodule

// File: rtl/aof_serializer.sv
module aof_serializer
  import aof_pkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int SLOT_BITS = 32
) (
  input  logic [$clog2(2*SLOT_BITS)-1:0] bit_i,
  input  rate_e                          rate_i,
  input  logic [SAMPLE_W-1:0]            left_i,
  input  logic [SAMPLE_W-1:0]            right_i,
  output logic                           sdata_o
);

  localparam int SL   = $clog2(SLOT_BITS);
  localparam int HL   = SL - 1;
  localparam int BW   = SL + 1;
  localparam int PW   = SL + 1;
  localparam int HALF = SLOT_BITS / 2;

  logic [PW-1:0]       pos, span, lead, idx;
  logic                chan;
  logic [SAMPLE_W-1:0] word, shifted;

  always_comb begin
    if (rate_i == RATE_2FS) begin
      pos  = PW'(bit_i[HL-1:0]);
      chan = bit_i[HL];
      span = PW'(HALF);
    end else begin
      pos  = PW'(bit_i[SL-1:0]);
      chan = bit_i[BW-1];
      span = PW'(SLOT_BITS);
    end
    lead    = span - PW'(SAMPLE_W);
    idx     = span - pos - 1'b1;
    word    = chan ? right_i : left_i;
    shifted = word >> idx;
    sdata_o = (pos >= lead) ? shifted[0] : 1'b0;
  end

endmodule

// File: rtl/aud_out_fmt.sv
module aud_out_fmt
  import aof_pkg::*;
#(
  parameter int DIV       = 5,
  parameter int SLOT_BITS = 32,
  parameter int SAMPLE_W  = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  input  logic                valid_i,
  output logic                ready_o,
  input  logic                rate_i,
  input  logic                pass_i,
  output logic                bclk_o,
  output logic                lrclk_o,
  output logic                wclk_o,
  output logic                sdata_o
);

  localparam int BW = $clog2(2 * SLOT_BITS);

  logic                rst_meta_q, rst_sync_q;
  logic [BW-1:0]       bit_w;
  logic                edge_w, load_w;
  rate_e               rate_w;
  logic [SAMPLE_W-1:0] cur_l_w, cur_r_w;

  // reset release synchroniser
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  aof_timing #(
    .DIV       (DIV),
    .SLOT_BITS (SLOT_BITS)
  ) u_timing (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_q),
    .rate_i     (rate_i),
    .pass_i     (pass_i),
    .bit_o      (bit_w),
    .bit_edge_o (edge_w),
    .load_o     (load_w),
    .rate_o     (rate_w),
    .bclk_o     (bclk_o),
    .lrclk_o    (lrclk_o),
    .wclk_o     (wclk_o)
  );

  aof_pair_buf #(
    .SAMPLE_W (SAMPLE_W)
  ) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_q),
    .left_i  (left_i),
    .right_i (right_i),
    .valid_i (valid_i),
    .ready_o (ready_o),
    .load_i  (load_w),
    .left_o  (cur_l_w),
    .right_o (cur_r_w)
  );

  aof_serializer #(
    .SAMPLE_W  (SAMPLE_W),
    .SLOT_BITS (SLOT_BITS)
  ) u_ser (
    .bit_i   (bit_w),
    .rate_i  (rate_w),
    .left_i  (cur_l_w),
    .right_i (cur_r_w),
    .sdata_o (sdata_o)
  );

  // serial outputs move only with a falling bit clock
  assert_out_on_fall_R12: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    (!$stable(sdata_o) || !$stable(lrclk_o) || !$stable(wclk_o)) |-> (edge_w && !bclk_o));

endmodule

// File: tb/aud_out_fmt_bench.sv
module aud_out_fmt_bench;

  localparam int SW   = 12;
  localparam int SB   = 32;
  localparam int DV   = 5;
  localparam int HALF = SB / 2;
  localparam int FB   = 2 * SB;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [SW-1:0] left, right;
  logic          valid, ready, rate, pass;
  logic          bclk, lrclk, wclk, sdata;

  int n_chk  = 0;
  int n_fail = 0;
  int frame_cnt = 0;
  bit idle = 0;
  bit chg  = 0;

  logic [2*SW-1:0] exp_q[$];
  logic [2*SW-1:0] last_pair = '0;

  always #5 clk = ~clk;

  aud_out_fmt #(
    .DIV       (DV),
    .SLOT_BITS (SB),
    .SAMPLE_W  (SW)
  ) u_aud_out_fmt (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .left_i  (left),
    .right_i (right),
    .valid_i (valid),
    .ready_o (ready),
    .rate_i  (rate),
    .pass_i  (pass),
    .bclk_o  (bclk),
    .lrclk_o (lrclk),
    .wclk_o  (wclk),
    .sdata_o (sdata)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  // scoreboard compare of one decoded pair
  task automatic compare(input logic [SW-1:0] l, input logic [SW-1:0] r);
    logic [2*SW-1:0] p;
    p = {l, r};
    if (idle) begin
      chk(p == last_pair, "R8", p, last_pair);
    end else if (exp_q.size() > 0 && p == exp_q[0]) begin
      last_pair = exp_q.pop_front();
      chk(1'b1, "R7", p, p);
    end else begin
      chk(p == last_pair, "R7", p, (exp_q.size() > 0) ? exp_q[0] : last_pair);
    end
  endtask

  task automatic decode(input logic [FB-1:0] fb, input bit r2, input bit changed);
    logic [SW-1:0] s[2];
    bit            ok;
    string         tag;
    if (!r2) begin
      tag = changed ? "R10" : "R5";
      for (int ch = 0; ch < 2; ch++) begin
        ok = 1;
        for (int k = 0; k < SB - SW; k++) if (fb[ch*SB + k]) ok = 0;
        for (int j = 0; j < SW; j++) s[ch][SW-1-j] = fb[ch*SB + SB - SW + j];
        chk(ok, tag, ok, 1);
      end
      compare(s[0], s[1]);
    end else begin
      tag = changed ? "R10" : "R6";
      for (int w = 0; w < 2; w++) begin
        for (int ch = 0; ch < 2; ch++) begin
          ok = 1;
          for (int k = 0; k < HALF - SW; k++) if (fb[w*SB + ch*HALF + k]) ok = 0;
          for (int j = 0; j < SW; j++) s[ch][SW-1-j] = fb[w*SB + ch*HALF + HALF - SW + j];
          chk(ok, tag, ok, 1);
        end
        compare(s[0], s[1]);
      end
    end
  endtask

  // monitor: rebuild frames from the serial pins
  initial begin : monitor
    logic          pb = 1'b0, plr = 1'b0, psd = 1'b0, plr2 = 1'b0, pw = 1'b0;
    int            cnt = 0;
    int            bp = 0;
    bit            synced = 0;
    bit            fr = 0, fp = 0;
    logic [FB-1:0] fb = '0;
    logic          exp_w;
    while (!rst_n) @(negedge clk);
    forever begin
      @(negedge clk);
      cnt++;
      if (synced && (sdata != psd || lrclk != plr2 || wclk != pw))
        chk(!bclk && pb, "R12", {bclk, pb}, 2'b01);
      psd = sdata; plr2 = lrclk; pw = wclk;
      if (bclk && !pb) begin
        if (synced) chk(cnt == DV, "R1", cnt, DV);
        cnt = 0;
        if (!lrclk && plr) begin
          if (synced) chk(bp == FB, "R2", bp, FB);
          synced = 1; bp = 0; fr = rate; fp = pass;
          frame_cnt++;
        end
        plr = lrclk;
        if (synced && bp < FB) begin
          fb[bp] = sdata;
          chk(lrclk == (bp >= SB), "R2", lrclk, bp >= SB);
          exp_w = fp ? 1'b0 : ((bp % SB) < HALF);
          if (fp) chk(wclk == exp_w, "R4", wclk, exp_w);
          else    chk(wclk == exp_w, "R3", wclk, exp_w);
          bp++;
          if (bp == FB) begin
            decode(fb, fr, chg);
            chg = 0;
          end
        end
      end
      pb = bclk;
    end
  end

  task automatic send(input logic [SW-1:0] l, input logic [SW-1:0] r);
    bit acc;
    valid = 1'b1; left = l; right = r;
    do begin
      acc = ready;
      @(negedge clk);
    end while (!acc);
    exp_q.push_back({l, r});
    valid = 1'b0;
    chk(ready == 1'b0, "R9", ready, 0);
  endtask

  task automatic wait_frame();
    int f;
    f = frame_cnt;
    while (frame_cnt == f) @(negedge clk);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete");
    summary();
    $finish;
  end

  initial begin : driver
    rst_n = 1'b0; valid = 1'b0; rate = 1'b0; pass = 1'b0; left = '0; right = '0;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk(bclk == 1'b0,  "R11", bclk, 0);
    chk(lrclk == 1'b0, "R11", lrclk, 0);
    chk(sdata == 1'b0, "R11", sdata, 0);
    chk(ready == 1'b1, "R11", ready, 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // normal-rate streaming (R5, R7, R9)
    for (int i = 0; i < 6; i++) send(SW'(12'h9A5 ^ (i * 12'h137)), SW'(12'h3C6 + i * 12'h2D1));
    drain();
    wait_frame();
    // starvation: pair repeats (R8)
    idle = 1;
    repeat (3) wait_frame();
    idle = 0;

    // switch to double rate in mid-frame (R10, R6)
    wait_frame();
    repeat (40) @(negedge clk);
    rate = 1'b1; chg = 1;
    for (int i = 0; i < 8; i++) send(SW'(12'hF01 - i * 12'h0B3), SW'(12'h812 ^ (i * 12'h55)));
    drain();

    // pass-through in double rate (R4)
    wait_frame();
    pass = 1'b1;
    for (int i = 0; i < 4; i++) send(SW'(12'h6E9 + i), SW'(12'hA17 - i));
    drain();
    wait_frame();
    wait_frame();

    // back to normal rate, pass-through off
    pass = 1'b0; rate = 1'b0; chg = 1;
    for (int i = 0; i < 3; i++) send(SW'(12'h4B2 * (i + 1)), SW'(12'hC3D ^ (i << 4)));
    drain();
    repeat (2) wait_frame();

    chk(exp_q.size() == 0, "R7", exp_q.size(), 0);
    summary();
    $finish;
  end

endmodule